// File: doc/BRIEF.md
# Bipolar Line Code Encoder

The encoder turns a serial unipolar NRZ bit stream, one bit per encode clock, into two unipolar return-to-zero rails. One rail carries positive marks and the other carries negative marks. An external network sums the two rails into a ternary line signal. A two-bit line-code select picks one of four codes. The first is plain alternate mark inversion. The other three replace long zero runs with patterns that deliberately break the alternation, so the line keeps enough pulses for clock recovery downstream. The three run lengths are eight zeros, six zeros and four zeros.

Incoming bits pass through a fixed-length buffer. A whole zero run is therefore visible, and can be rewritten, before its first bit leaves. Latency is the same in every code, so a loopback path sees a constant delay. Two output controls override the encoded data. One silences both rails. The other sends a continuous alarm stream of alternating marks. Each registered rail is ANDed with the high phase of the encode clock, which gives marks of half-period width.

Top module: `bzs_encoder`

## Requirements
- R1: At any instant at most one rail is high. Both rails are low whenever `clk` is low, so each mark lasts only for the high phase that follows the rising edge that produced it.
- R2: In code 0 (alternate mark inversion), a 0 bit gives no pulse. A 1 bit gives a mark whose polarity is opposite to the previous mark. After reset, the previous mark counts as negative, so the first mark is positive.
- R3: In code 1, every run of eight 0 bits is sent as 0,0,0,V,B,0,V,B, oldest first. V repeats the polarity of the mark before it. B takes the opposite polarity, and the alternation continues after B.
- R4: In code 2, every run of six 0 bits is sent as 0,V,B,0,V,B, oldest first, using the V and B rules of R3.
- R5: In code 3, every run of four 0 bits is replaced. It becomes 0,0,0,V when an odd number of 1 bits has arrived since the last replacement, and B,0,0,V when that number is even. The count starts at zero after reset.
- R6: A bit sampled at rising edge k drives the rails in the high phase after edge k+9. Before edge 9 after reset, data produces no marks.
- R7: When `out_dis` is high at a rising edge, both rails stay low through the following clock period. The encoder state keeps advancing while the rails are held low.
- R8: When `force_ais` is high at a rising edge and `out_dis` is low, the rails carry a normal alternating mark in place of the buffered symbol. `out_dis` takes priority over `force_ais`.
- R9: While `rst_n` is low, both rails stay low. Reset clears the buffer, the zero-run count, the parity count and the polarity state.
- R10: The code select is captured only on rising edges while `rst_n` is low. Changes to `mode` after reset is released have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encode clock; its high phase also shapes the marks |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Line code: 0 mark inversion, 1 eight-zero, 2 six-zero, 3 four-zero |
| nrz_in | input | 1 | Serial NRZ data bit |
| out_dis | input | 1 | Forces both rails low |
| force_ais | input | 1 | Replaces data with an alternating all-ones mark stream |
| rail_p | output | 1 | Positive-mark rail, return-to-zero |
| rail_n | output | 1 | Negative-mark rail, return-to-zero |

## Verification
The hardest case to reach is the parity-dependent choice in the four-zero code. The even-parity form, which begins with a balancing B pulse, appears only when a zero run follows an even number of ones since the last replacement. The stimulus for each code phase therefore starts with a directed prefix: a single one followed by a long zero run. This forces the odd form, and back-to-back replacements give the even form. Zero-heavy random data then supplies many runs of mixed parity. A later phase mixes random rail disables and alarm insertions into the four-zero code. This confirms that polarity keeps advancing underneath a silenced output.

// File: rtl/bzs_pkg.sv
package bzs_pkg;

  // Symbols held in the substitution buffer.
  typedef enum logic [1:0] {
    SYM_ZERO = 2'd0,
    SYM_ONE  = 2'd1,
    SYM_VIOL = 2'd2,
    SYM_BAL  = 2'd3
  } sym_t;

  // Line code select; the numeric values are visible at the mode port.
  typedef enum logic [1:0] {
    LC_AMI = 2'd0,
    LC_Z8  = 2'd1,
    LC_Z6  = 2'd2,
    LC_Z4  = 2'd3
  } lcode_t;

  // Zero-run length that triggers a replacement (0 means never).
  function automatic logic [31:0] run_len(lcode_t m);
    case (m)
      LC_Z8:   return 32'd8;
      LC_Z6:   return 32'd6;
      LC_Z4:   return 32'd4;
      default: return 32'd0;
    endcase
  endfunction

  // Replacement symbol at buffer slot j, counted from the newest bit.
  function automatic sym_t fill_sym(lcode_t m, logic odd, logic [31:0] j);
    sym_t s;
    s = SYM_ZERO;
    case (m)
      LC_Z8, LC_Z6: begin
        if (j == 32'd0 || j == 32'd3) s = SYM_BAL;
        else if (j == 32'd1 || j == 32'd4) s = SYM_VIOL;
      end
      LC_Z4: begin
        if (j == 32'd0) s = SYM_VIOL;
        else if (j == 32'd3 && !odd) s = SYM_BAL;
      end
      default: s = SYM_ZERO;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/bzs_subst_buffer.sv
module bzs_subst_buffer
  import bzs_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   bit_i,
  input  lcode_t mode_i,
  output sym_t   head_o,
  output logic   sub_fire_o
);
  localparam int ZW = $clog2(DEPTH + 1);

  logic          bit_q;
  logic          primed_q;
  logic          odd_q;
  logic [ZW-1:0] zrun_q;
  sym_t          line_q  [DEPTH];
  sym_t          line_d  [DEPTH];
  sym_t          shift_v [DEPTH];
  logic [31:0]   run_n;

  assign run_n = run_len(mode_i);

  // The zero now entering completes a run of the selected length.
  assign sub_fire_o = primed_q && !bit_q && (run_n != 32'd0) &&
                      ((32'(zrun_q) + 32'd1) == run_n);

  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    if (j == 0) begin : g_tail
      assign shift_v[j] = bit_q ? SYM_ONE : SYM_ZERO;
    end else begin : g_mid
      assign shift_v[j] = line_q[j-1];
    end
    assign line_d[j] = (sub_fire_o && (32'(j) < run_n)) ?
                       fill_sym(mode_i, odd_q, 32'(j)) : shift_v[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q    <= 1'b0;
      primed_q <= 1'b0;
      odd_q    <= 1'b0;
      zrun_q   <= '0;
      for (int k = 0; k < DEPTH; k++) line_q[k] <= SYM_ZERO;
    end else begin
      bit_q    <= bit_i;
      primed_q <= 1'b1;
      line_q   <= line_d;
      if (!primed_q || bit_q || sub_fire_o) zrun_q <= '0;
      else if (zrun_q != ZW'(DEPTH))        zrun_q <= zrun_q + 1'b1;
      if (sub_fire_o)              odd_q <= 1'b0;
      else if (primed_q && bit_q)  odd_q <= ~odd_q;
    end
  end

  assign head_o = line_q[DEPTH-1];

endmodule

// File: rtl/bzs_rail_driver.sv
module bzs_rail_driver
  import bzs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  sym_t head_i,
  input  logic dis_i,
  input  logic ais_i,
  output logic mark_p_o,
  output logic mark_n_o
);
  logic neg_next_q, neg_next_d;
  logic p_d, n_d;
  sym_t sym_eff;

  always_comb begin
    sym_eff    = ais_i ? SYM_ONE : head_i;
    p_d        = 1'b0;
    n_d        = 1'b0;
    neg_next_d = neg_next_q;
    case (sym_eff)
      SYM_ONE, SYM_BAL: begin
        p_d        = !neg_next_q;
        n_d        = neg_next_q;
        neg_next_d = !neg_next_q;
      end
      SYM_VIOL: begin
        p_d = neg_next_q;
        n_d = !neg_next_q;
      end
      default: ;
    endcase
    if (dis_i) begin
      p_d = 1'b0;
      n_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_next_q <= 1'b0;
      mark_p_o   <= 1'b0;
      mark_n_o   <= 1'b0;
    end else begin
      neg_next_q <= neg_next_d;
      mark_p_o   <= p_d;
      mark_n_o   <= n_d;
    end
  end

endmodule

// File: rtl/bzs_encoder.sv
module bzs_encoder
  import bzs_pkg::*;
#(
  parameter int RUN_MAX = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       nrz_in,
  input  logic       out_dis,
  input  logic       force_ais,
  output logic       rail_p,
  output logic       rail_n
);
  logic [1:0] mode_q;
  sym_t       head;
  logic       sub_fire;
  logic       mark_p_q, mark_n_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= mode;
  end

  bzs_subst_buffer #(.DEPTH(RUN_MAX)) i_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_i     (nrz_in),
    .mode_i    (lcode_t'(mode_q)),
    .head_o    (head),
    .sub_fire_o(sub_fire)
  );

  bzs_rail_driver i_drv (
    .clk     (clk),
    .rst_n   (rst_n),
    .head_i  (head),
    .dis_i   (out_dis),
    .ais_i   (force_ais),
    .mark_p_o(mark_p_q),
    .mark_n_o(mark_n_q)
  );

  assign rail_p = mark_p_q & clk;
  assign rail_n = mark_n_q & clk;

endmodule

// File: rtl/bzs_encoder_chk.sv
module bzs_encoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       out_dis,
  input logic       force_ais,
  input logic       mark_p_q,
  input logic       mark_n_q,
  input logic       sub_fire,
  input logic [1:0] mode_q
);

  a_r1_single_rail: assert property (@(posedge clk) disable iff (!rst_n)
    !(mark_p_q && mark_n_q));

  a_r7_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    out_dis |=> (!mark_p_q && !mark_n_q));

  a_r8_alarm_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (force_ais && !out_dis) |=> (mark_p_q != mark_n_q));

  a_r2_ami_alt_p: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd0 && mark_p_q) |=> !mark_p_q);

  a_r2_ami_alt_n: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd0 && mark_n_q) |=> !mark_n_q);

  a_r3_no_subst_plain: assert property (@(posedge clk) disable iff (!rst_n)
    sub_fire |-> (mode_q != 2'd0));

endmodule

bind bzs_encoder bzs_encoder_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .out_dis  (out_dis),
  .force_ais(force_ais),
  .mark_p_q (mark_p_q),
  .mark_n_q (mark_n_q),
  .sub_fire (sub_fire),
  .mode_q   (mode_q)
);

// File: tb/test_bzs_encoder.sv
module test_bzs_encoder;
  localparam int NMAX = 800;
  localparam int LAT  = 9;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       nrz_in = 1'b0, out_dis = 1'b0, force_ais = 1'b0;
  logic       rail_p, rail_n;

  int errors = 0, checks = 0;
  bit done = 0;

  int bits [NMAX];
  int sym  [NMAX];   // 0 zero, 1 one, 2 V, 3 B
  bit dis_a[NMAX];
  bit ais_a[NMAX];

  always #4 clk = ~clk;

  bzs_encoder i_bzs_encoder (
    .clk(clk), .rst_n(rst_n), .mode(mode), .nrz_in(nrz_in),
    .out_dis(out_dis), .force_ais(force_ais), .rail_p(rail_p), .rail_n(rail_n)
  );

  task automatic check2(string req, logic ap, logic an, logic ep, logic en, int cyc);
    checks++;
    if (ap !== ep || an !== en) begin
      errors++;
      $display("FAIL %s cycle %0d: rails p/n = %b%b expected %b%b", req, cyc, ap, an, ep, en);
    end
  endtask

  function automatic int zlen(int m);
    return (m == 1) ? 8 : (m == 2) ? 6 : (m == 3) ? 4 : 0;
  endfunction

  task automatic build_syms(int m, int n);
    int run = 0;
    bit odd = 0;
    string pat;
    for (int i = 0; i < n; i++) begin
      sym[i] = bits[i];
      if (bits[i] == 1) begin
        run = 0;
        odd = ~odd;
      end else begin
        run++;
        if (zlen(m) > 0 && run == zlen(m)) begin
          if (m == 1) pat = "000VB0VB";
          else if (m == 2) pat = "0VB0VB";
          else pat = odd ? "000V" : "B00V";
          for (int k = 0; k < zlen(m); k++)
            sym[i - zlen(m) + 1 + k] = (pat[k] == "V") ? 2 : (pat[k] == "B") ? 3 : 0;
          run = 0;
          odd = 0;
        end
      end
    end
  endtask

  // Reset, capture code m, then run n cycles; the mode pin moves to alt after release if chg.
  task automatic run_phase(int m, int n, string tag, bit chg, int alt);
    int prev = -1;
    int s, sg;
    logic ep, en;
    string req;
    build_syms(m, n);
    @(negedge clk);
    rst_n = 1'b0; mode = 2'(m); nrz_in = 0; out_dis = 0; force_ais = 0;
    repeat (3) @(negedge clk);
    @(posedge clk); #2;
    check2("R9", rail_p, rail_n, 1'b0, 1'b0, -1);
    for (int e = 0; e < n; e++) begin
      @(negedge clk); #1;
      check2("R1", rail_p, rail_n, 1'b0, 1'b0, e);
      nrz_in = bits[e][0]; out_dis = dis_a[e]; force_ais = ais_a[e];
      if (e == 0) rst_n = 1'b1;
      if (chg && e == 1) mode = 2'(alt);
      @(posedge clk); #2;
      s = (e >= LAT) ? sym[e - LAT] : 0;
      if (ais_a[e]) s = 1;
      sg = 0;
      if (s == 1 || s == 3) begin sg = -prev; prev = sg; end
      else if (s == 2) sg = prev;
      ep = (sg > 0); en = (sg < 0);
      if (dis_a[e]) begin ep = 0; en = 0; end
      if (dis_a[e]) req = "R7";
      else if (ais_a[e]) req = "R8";
      else if (e < LAT) req = "R6";
      else req = tag;
      check2(req, rail_p, rail_n, ep, en, e);
    end
  endtask

  task automatic gen(int n, bit ctl, int dens);
    for (int i = 0; i < n; i++) begin
      if (i < 14) bits[i] = (i == 0) ? 1 : 0;
      else bits[i] = ($urandom_range(0, dens - 1) == 0) ? 1 : 0;
      dis_a[i] = ctl && ($urandom_range(0, 7) == 0);
      ais_a[i] = ctl && ($urandom_range(0, 7) == 0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    gen(300, 0, 2); run_phase(0, 300, "R2", 0, 0);
    gen(600, 0, 4); run_phase(1, 600, "R3", 0, 0);
    gen(600, 0, 4); run_phase(2, 600, "R4", 0, 0);
    gen(600, 0, 3); run_phase(3, 600, "R5", 0, 0);
    // all-zero stretch right after reset: back-to-back replacements, even parity
    for (int i = 0; i < 120; i++) begin bits[i] = 0; dis_a[i] = 0; ais_a[i] = 0; end
    run_phase(3, 120, "R5", 0, 0);
    gen(500, 1, 3); run_phase(3, 500, "R5", 0, 0);
    gen(400, 0, 4); run_phase(1, 400, "R10", 1, 0);
    gen(300, 0, 4); run_phase(0, 300, "R10", 1, 3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule